// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 128K bytes. The host makes requests of one cycle through a valid/ready handshake. Each request carries a write flag, a 17-bit address and, for writes, 8 bits of data. The controller turns each accepted request into a timed sequence of strobes on the memory pins:

- an active-low select and an active-high select,
- an active-low output enable,
- an active-low write enable,
- a data bus split into a driven value, a drive enable and a sampled input.

Read data returns to the host with a valid pulse of one cycle.

Every minimum or maximum memory timing is a parameter in nanoseconds. Each one is turned into a clock count by ceiling division by the clock period, with a floor of one cycle. Phase counters hold each phase until its count has run out. After each read, a high-Z window keeps the controller's own bus driver off until the memory has released the bus. A power-down input lets the access in progress finish, then deselects the RAM through both selects and refuses new requests.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset the block shows the idle state: ce1_n=0, ce2=1, oe_n=1, we_n=1, dq_oe=0, rsp_valid=0, and req_ready=1 while pd_i is low.
- R2: A read holds ce1_n=0, ce2=1, oe_n=0, we_n=1 and dq_oe=0 for exactly RD_CYC cycles. RD_CYC is the largest of the counts for read cycle time, address access time and output-enable access time. The phase starts on the clock after acceptance.
- R3: The value on mem_dq_i in the last read-phase cycle appears on rsp_rdata_o together with rsp_valid_o=1 on the next cycle. rsp_valid_o is high for exactly one cycle.
- R4: A write holds we_n=0 and oe_n=1 for WP_CYC cycles, with dq_oe=1 and mem_dq_o equal to the request data. WP_CYC is the larger of the counts for write pulse width and data setup.
- R5: After the write pulse, we_n returns high for REC_CYC cycles while data stays driven and the address stays unchanged. REC_CYC is the write-cycle count minus WP_CYC, with a floor of 1.
- R6: After every read, oe_n stays high and dq_oe stays low for HZ_CYC cycles (the count for the bus release time). dq_oe is never 1 while oe_n is 0.
- R7: mem_addr_o takes the request address on acceptance and holds it unchanged until the access ends.
- R8: req_ready_o is high only in idle with pd_i low. Each accepted request produces exactly one access.
- R9: When pd_i is raised, any access in progress completes. The block then drives ce1_n=1 and ce2=0 together and holds req_ready_o low. After pd_i falls it returns to idle with ce1_n=0 and ce2=1.
- R10: The time-to-cycles conversion is ceil(t/period) with a minimum of 1. For example, 17 ns at a 20 ns period gives 1 cycle and 41 ns gives 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Power-down request |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_rdata_o | output | DATA_W | Read data |
| rsp_valid_o | output | 1 | Read data valid, one cycle |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_ce1_n_o | output | 1 | RAM select, active low |
| mem_ce2_o | output | 1 | RAM select, active high |
| mem_oe_n_o | output | 1 | RAM output enable, active low |
| mem_we_n_o | output | 1 | RAM write enable, active low |
| mem_dq_o | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | DATA_W | Data sampled from the RAM bus |

## Verification
A phase counter that loaded the wrong value would show on the pins as a strobe held too long or too short. The bench measures this directly at a fast clock ratio, where phases last several cycles, in the very access where the fault occurs.

A wrong state in the sequencer shows one of three ways:
- the output enable is low while the controller drives the bus,
- the write enable is low with the output enable low,
- the two selects disagree.

All three are flagged on the same cycle. A lost capture of the read data shows as a missing or stale response pulse one cycle after the read phase.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_HZ,
    ST_WR,
    ST_WR_REC,
    ST_PARK
  } state_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic oe_n;
    logic we_n;
    logic drv;
  } strobes_t;

  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/asram_strobe_dec.sv
module asram_strobe_dec
  import asram_pkg::*;
(
  input  state_e   state_i,
  output strobes_t strb_o
);
  always_comb begin
    strb_o.ce1_n = (state_i == ST_PARK);
    strb_o.ce2   = (state_i != ST_PARK);
    strb_o.oe_n  = (state_i != ST_RD);
    strb_o.we_n  = (state_i != ST_WR);
    strb_o.drv   = (state_i == ST_WR) || (state_i == ST_WR_REC);
  end
endmodule

// File: rtl/asram_data_path.sv
module asram_data_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_wdata_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o     <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      if (load_wdata_i) dq_o    <= wdata_i;
      if (capture_i)    rdata_o <= dq_i;
      rvalid_o <= capture_i;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 20,
  parameter int unsigned T_RC_NS = 17,
  parameter int unsigned T_AA_NS = 17,
  parameter int unsigned T_OE_NS = 9,
  parameter int unsigned T_WC_NS = 17,
  parameter int unsigned T_WP_NS = 13,
  parameter int unsigned T_DS_NS = 9,
  parameter int unsigned T_HZ_NS = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce1_n_o,
  output logic              mem_ce2_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned RD_CYC  = max2(max2(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                         ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int unsigned HZ_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned WP_CYC  = max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned REC_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, HZ_CYC), max2(WP_CYC, REC_CYC));
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LD  = CNT_W'(HZ_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

  state_e           state_q, state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             done;
  logic             accept;
  logic             capture;
  strobes_t         strb_d, strb_q;
  logic [ADDR_W-1:0] addr_q;

  assign req_ready_o = (state_q == ST_IDLE) && !pd_i;
  assign accept      = req_valid_i && req_ready_o;

  asram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pd_i) begin
          state_d = ST_PARK;
        end else if (accept) begin
          load = 1'b1;
          if (req_we_i) begin
            state_d  = ST_WR;
            load_val = WP_LD;
          end else begin
            state_d  = ST_RD;
            load_val = RD_LD;
          end
        end
      end
      ST_RD: if (done) begin
        capture  = 1'b1;
        state_d  = ST_RD_HZ;
        load     = 1'b1;
        load_val = HZ_LD;
      end
      ST_RD_HZ: if (done) state_d = ST_IDLE;
      ST_WR: if (done) begin
        state_d  = ST_WR_REC;
        load     = 1'b1;
        load_val = REC_LD;
      end
      ST_WR_REC: if (done) state_d = ST_IDLE;
      ST_PARK:   if (!pd_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  asram_strobe_dec i_dec (
    .state_i (state_d),
    .strb_o  (strb_d)
  );

  // strobes are registered from the next state so pins never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      strb_q  <= '{ce1_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      strb_q  <= strb_d;
      if (accept) addr_q <= req_addr_i;
    end
  end

  asram_data_path #(.DATA_W(DATA_W)) i_data (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_wdata_i (accept && req_we_i),
    .wdata_i      (req_wdata_i),
    .capture_i    (capture),
    .dq_i         (mem_dq_i),
    .dq_o         (mem_dq_o),
    .rdata_o      (rsp_rdata_o),
    .rvalid_o     (rsp_valid_o)
  );

  assign mem_addr_o  = addr_q;
  assign mem_ce1_n_o = strb_q.ce1_n;
  assign mem_ce2_o   = strb_q.ce2;
  assign mem_oe_n_o  = strb_q.oe_n;
  assign mem_we_n_o  = strb_q.we_n;
  assign mem_dq_oe_o = strb_q.drv;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned HZ_CYC = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce1_n_o,
  input logic              mem_ce2_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic              mem_dq_oe_o
);
  logic [7:0] oe_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       oe_hi_cnt <= 8'(HZ_CYC);
    else if (!mem_oe_n_o)              oe_hi_cnt <= '0;
    else if (oe_hi_cnt < 8'(HZ_CYC))   oe_hi_cnt <= oe_hi_cnt + 1'b1;
  end

  a_r6_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);

  a_r6_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (oe_hi_cnt >= 8'(HZ_CYC)));

  a_r4_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_oe_n_o);

  a_r9_deselect_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce1_n_o == !mem_ce2_o);

  a_r9_park_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce1_n_o |-> !req_ready_o);

  a_r7_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!mem_oe_n_o || !mem_we_n_o) && $past(!mem_oe_n_o || !mem_we_n_o)) |-> $stable(mem_addr_o));

  a_r3_rvalid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r8_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!mem_oe_n_o || !mem_we_n_o));
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .HZ_CYC(HZ_CYC)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ce1_n_o (mem_ce1_n_o),
  .mem_ce2_o   (mem_ce2_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // main instance, 20 ns clock: every phase one cycle
  logic        pd, valid, we, ready, rvalid, ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [16:0] addr, maddr;
  logic [7:0]  wdata, rdata, dq_o, dq_i;

  asram_ctrl i_asram_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pd_i(pd), .req_valid_i(valid), .req_ready_o(ready),
    .req_we_i(we), .req_addr_i(addr), .req_wdata_i(wdata), .rsp_rdata_o(rdata),
    .rsp_valid_o(rvalid), .mem_addr_o(maddr), .mem_ce1_n_o(ce1_n), .mem_ce2_o(ce2),
    .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe),
    .mem_dq_i(dq_i));

  // slow-memory instance: 5 ns period -> RD=4, HZ=2, WP=3, REC=1
  logic        s_valid, s_we, s_ready, s_rvalid, s_ce1_n, s_ce2, s_oe_n, s_we_n, s_dq_oe;
  logic [16:0] s_maddr;
  logic [7:0]  s_rdata, s_dq_o;

  asram_ctrl #(.CLK_NS(5)) i_asram_ctrl_slow (
    .clk_i(clk), .rst_ni(rst_ni), .pd_i(1'b0), .req_valid_i(s_valid), .req_ready_o(s_ready),
    .req_we_i(s_we), .req_addr_i(17'h1ABCD), .req_wdata_i(8'h3C), .rsp_rdata_o(s_rdata),
    .rsp_valid_o(s_rvalid), .mem_addr_o(s_maddr), .mem_ce1_n_o(s_ce1_n), .mem_ce2_o(s_ce2),
    .mem_oe_n_o(s_oe_n), .mem_we_n_o(s_we_n), .mem_dq_o(s_dq_o), .mem_dq_oe_o(s_dq_oe),
    .mem_dq_i(8'h5A));

  // RAM model
  logic [7:0] ram [int unsigned];
  logic       ram_drive;
  int         conflicts = 0;

  always_comb begin
    ram_drive = !ce1_n && ce2 && !oe_n && we_n;
    if (ram_drive) dq_i = ram.exists(int'(maddr)) ? ram[int'(maddr)] : 8'h00;
    else           dq_i = 8'hEE;
  end

  always @(posedge clk) begin
    if (rst_ni && !ce1_n && ce2 && !we_n && dq_oe) ram[int'(maddr)] = dq_o;
  end
  always @(negedge clk) if (rst_ni && ram_drive && dq_oe) conflicts++;

  logic [7:0] shadow [int unsigned];

  localparam logic [25:0] VEC [0:11] = '{
    {1'b1, 17'h00000, 8'hA5}, {1'b1, 17'h1FFFF, 8'h5A}, {1'b1, 17'h00123, 8'h0F},
    {1'b0, 17'h00000, 8'h00}, {1'b0, 17'h1FFFF, 8'h00}, {1'b1, 17'h10000, 8'hFF},
    {1'b0, 17'h00123, 8'h00}, {1'b1, 17'h00000, 8'h33}, {1'b0, 17'h00000, 8'h00},
    {1'b0, 17'h10000, 8'h00}, {1'b0, 17'h0ABCD, 8'h00}, {1'b1, 17'h0ABCD, 8'hC3}
  };

  task automatic access(input logic w, input logic [16:0] a, input logic [7:0] d);
    logic [7:0] exp;
    @(negedge clk);
    valid = 1'b1; we = w; addr = a; wdata = d;
    chk(ready == 1'b1, "R8 ready in idle", ready, 1);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    addr  = ~a;
    if (w) begin
      chk({we_n, oe_n, dq_oe} == 3'b011, "R4 write strobes", {we_n, oe_n, dq_oe}, 3'b011);
      chk(dq_o == d, "R4 write data", dq_o, d);
      chk(maddr == a, "R7 address", maddr, a);
      @(negedge clk);
      chk({we_n, dq_oe} == 2'b11, "R5 recovery", {we_n, dq_oe}, 2'b11);
      chk(maddr == a, "R5 address held", maddr, a);
      shadow[int'(a)] = d;
    end else begin
      exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      chk({ce1_n, ce2, oe_n, we_n, dq_oe} == 5'b01010, "R2 read strobes",
          {ce1_n, ce2, oe_n, we_n, dq_oe}, 5'b01010);
      chk(maddr == a, "R7 address", maddr, a);
      @(negedge clk);
      chk(rvalid == 1'b1 && rdata == exp, "R3 read data", {rvalid, rdata}, {1'b1, exp});
      chk({oe_n, dq_oe} == 2'b10, "R6 hz window", {oe_n, dq_oe}, 2'b10);
    end
    @(negedge clk);
    chk(ready == 1'b1 && rvalid == 1'b0, "R8 back to idle", {ready, rvalid}, 2'b10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    pd = 0; valid = 0; we = 0; addr = '0; wdata = '0; s_valid = 0; s_we = 0;
    repeat (3) @(negedge clk);
    chk({ce1_n, ce2, oe_n, we_n, dq_oe, rvalid, ready} == 7'b0111001, "R1 reset state",
        {ce1_n, ce2, oe_n, we_n, dq_oe, rvalid, ready}, 7'b0111001);
    rst_ni = 1'b1;

    // R10 conversion
    chk(asram_pkg::ns_to_cyc(17, 20) == 1, "R10 17/20", asram_pkg::ns_to_cyc(17, 20), 1);
    chk(asram_pkg::ns_to_cyc(41, 20) == 3, "R10 41/20", asram_pkg::ns_to_cyc(41, 20), 3);
    chk(asram_pkg::ns_to_cyc(40, 20) == 2, "R10 40/20", asram_pkg::ns_to_cyc(40, 20), 2);
    chk(asram_pkg::ns_to_cyc(0, 20) == 1, "R10 zero", asram_pkg::ns_to_cyc(0, 20), 1);

    foreach (VEC[i]) access(VEC[i][25], VEC[i][24:8], VEC[i][7:0]);
    access(1'b0, 17'h0ABCD, 8'h00);

    // R9: power-down during a read
    @(negedge clk);
    valid = 1'b1; we = 1'b0; addr = 17'h1FFFF;
    @(posedge clk);
    @(negedge clk);
    pd = 1'b1;
    chk(oe_n == 1'b0, "R9 access runs", oe_n, 0);
    @(negedge clk);
    chk(rvalid == 1'b1 && rdata == 8'h5A, "R9 access completes", {rvalid, rdata}, {1'b1, 8'h5A});
    repeat (2) @(negedge clk);
    chk({ce1_n, ce2, ready} == 3'b100, "R9 parked", {ce1_n, ce2, ready}, 3'b100);
    repeat (3) @(negedge clk);
    chk({oe_n, we_n, ready} == 3'b110, "R9 requests refused", {oe_n, we_n, ready}, 3'b110);
    valid = 1'b0; pd = 1'b0;
    @(negedge clk);
    chk({ce1_n, ce2, ready} == 3'b011, "R9 released", {ce1_n, ce2, ready}, 3'b011);
    chk(conflicts == 0, "R6 no bus contention", conflicts, 0);

    // slow instance: phase lengths
    @(negedge clk);
    s_valid = 1'b1; s_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    n = 0;
    while (!s_oe_n && n < 50) begin n++; @(negedge clk); end
    chk(n == 4, "R2 read length", n, 4);
    chk(s_rvalid && s_rdata == 8'h5A, "R3 slow capture", {s_rvalid, s_rdata}, {1'b1, 8'h5A});
    n = 0;
    while (!s_ready && n < 50) begin
      chk(!s_dq_oe, "R6 no drive in hz", s_dq_oe, 0);
      n++; @(negedge clk);
    end
    chk(n == 2, "R6 hz length", n, 2);
    s_valid = 1'b1; s_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    n = 0;
    while (!s_we_n && n < 50) begin n++; @(negedge clk); end
    chk(n == 3, "R4 write pulse length", n, 3);
    n = 0;
    while (s_dq_oe && n < 50) begin n++; @(negedge clk); end
    chk(n == 1, "R5 recovery length", n, 1);
    chk(s_maddr == 17'h1ABCD && s_ready, "R7 slow address", s_maddr, 17'h1ABCD);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule